// File: doc/BRIEF.md
# Selectable-Order PRBS Pattern Generator

This block is the pattern source of a bit error tester transmitter. It emits a maximal-length pseudo-random bit stream one bit per transmit bit clock. A single 23-stage shift register serves three sequence orders: 9, 15 and 23. Three one-hot enable inputs choose the order at run time.

The enables are normally driven by a control register. When exactly one enable is high, the block runs the matching Fibonacci shift register and flags each output bit as valid. Any change of the enables restarts the register from an all-ones seed, so the all-zero state can never be entered. With no enable high, or with more than one enable high, the output is forced to 0 and the valid flag is dropped.

The bit and the valid flag both come from registers. They change one clock edge after the enables that cause them are sampled.

Top module: `prbs_order_gen`

## Requirements
- R1: While the synchronous reset `rst` is high at a rising edge, `serOut` and `serValid` are 0 after that edge.
- R2: If exactly one of `enOrd9`, `enOrd15`, `enOrd23` is high at a rising edge (reset low), `serValid` is 1 after that edge, so a held legal enable yields one valid bit on every clock.
- R3: If none or more than one of the enables is high at a rising edge, `serOut` and `serValid` are 0 after that edge.
- R4: The stream for order 9 follows x^9+x^5+1. With state stages s1..s9, each clock emits s9, shifts every stage up by one, and loads s1 with s9 XOR s5. The stream repeats every 511 bits and holds 256 ones per period.
- R5: The stream for order 15 follows x^15+x^14+1. Each clock emits s15 and loads s1 with s15 XOR s14.
- R6: The stream for order 23 follows x^23+x^18+1. Each clock emits s23 and loads s1 with s23 XOR s18.
- R7: When the enables are legal and differ from the value sampled at the previous edge (reset clears that value to none), the register restarts from all ones. The stream then begins with N ones, where N is the order, and continues by the rule of R4 to R6.
- R8: While valid, the stream never holds N consecutive zeros, because the active N stages are never all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Transmit bit clock |
| rst | input | 1 | Synchronous reset, active high |
| enOrd9 | input | 1 | Selects the order-9 sequence |
| enOrd15 | input | 1 | Selects the order-15 sequence |
| enOrd23 | input | 1 | Selects the order-23 sequence |
| serOut | output | 1 | Serial pseudo-random bit |
| serValid | output | 1 | High when serOut carries a sequence bit |

## Verification
The hardest situations to reach are the full-period property of order 9 and a restart that interrupts a long stream part-way through. The stimulus holds the order-9 enable for more than two periods, so that periodicity and ones density can be measured on the observed bits. It then switches abruptly between orders, and passes through a no-enable gap and a two-enable gap back to the same order. Each switch must restart the all-ones seed no matter where the previous sequence had reached.

// File: rtl/prbs_pkg.sv
package prbs_pkg;

  typedef enum logic [1:0] {
    SEL_SHORT = 2'd0,
    SEL_MID   = 2'd1,
    SEL_LONG  = 2'd2
  } ordSel_t;

  // Strobes passed from control to datapath
  typedef struct packed {
    logic    legal;  // exactly one enable high
    logic    load;   // legal and different from last sampled enables
    ordSel_t sel;    // chosen order
  } prbsStrb_t;

endpackage

// File: rtl/prbs_ctrl.sv
module prbs_ctrl
  import prbs_pkg::*;
#(
  parameter int NUM_ORD = 3
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_ORD-1:0] enVec,
  output prbsStrb_t          strb
);

  logic [NUM_ORD-1:0] enPrev;

  always_ff @(posedge clk) begin
    if (rst) enPrev <= '0;
    else     enPrev <= enVec;
  end

  always_comb begin
    strb.legal = $onehot(enVec);
    strb.load  = strb.legal && (enVec != enPrev);
    strb.sel   = SEL_SHORT;
    for (int i = 0; i < NUM_ORD; i++) begin
      if (enVec[i]) strb.sel = ordSel_t'(i);
    end
  end

  // R7: an unchanged legal selection never requests a reload
  a_r7_hold_no_reload: assert property (@(posedge clk) disable iff (rst)
    (strb.legal && $stable(enVec) && $past(strb.legal)) |-> !strb.load);

endmodule

// File: rtl/prbs_datapath.sv
module prbs_datapath
  import prbs_pkg::*;
#(
  parameter int ORD_S = 9,
  parameter int TAP_S = 5,
  parameter int ORD_M = 15,
  parameter int TAP_M = 14,
  parameter int ORD_L = 23,
  parameter int TAP_L = 18,
  parameter int W     = 23
) (
  input  logic      clk,
  input  logic      rst,
  input  prbsStrb_t strb,
  output logic      bitOut,
  output logic      bitValid
);

  localparam int NUM_ORD = 3;
  localparam int ORDS [NUM_ORD] = '{ORD_S, ORD_M, ORD_L};
  localparam int TAPS [NUM_ORD] = '{TAP_S, TAP_M, TAP_L};
  localparam logic [W-1:0] SEED = {W{1'b1}};

  logic [W-1:0]       lfsr;
  ordSel_t            curSel;
  logic [NUM_ORD-1:0] fbVec;
  logic [NUM_ORD-1:0] msbVec;
  logic [W-1:0]       maskVec [NUM_ORD];

  // One tap network per supported order
  for (genvar g = 0; g < NUM_ORD; g++) begin : g_tap
    assign fbVec[g]   = lfsr[ORDS[g]-1] ^ lfsr[TAPS[g]-1];
    assign msbVec[g]  = lfsr[ORDS[g]-1];
    assign maskVec[g] = SEED >> (W - ORDS[g]);
  end

  always_ff @(posedge clk) begin
    if (rst || !strb.legal) begin
      lfsr     <= SEED;
      bitOut   <= 1'b0;
      bitValid <= 1'b0;
      curSel   <= SEL_SHORT;
    end else if (strb.load) begin
      // first step from the all-ones seed: emit 1, feedback 1^1 = 0
      lfsr     <= {SEED[W-2:0], 1'b0};
      bitOut   <= 1'b1;
      bitValid <= 1'b1;
      curSel   <= strb.sel;
    end else begin
      lfsr     <= {lfsr[W-2:0], fbVec[curSel]};
      bitOut   <= msbVec[curSel];
      bitValid <= 1'b1;
    end
  end

  // R1: reset clears the outputs
  a_r1_reset_quiet: assert property (@(posedge clk)
    rst |=> (!bitValid && !bitOut));

  // R7: a reload begins the stream with a one
  a_r7_seed_first_one: assert property (@(posedge clk) disable iff (rst)
    strb.load |=> (bitOut && bitValid));

  // R8: active stages never all zero while running
  a_r8_no_lockup: assert property (@(posedge clk) disable iff (rst)
    bitValid |-> ((lfsr & maskVec[curSel]) != '0));

endmodule

// File: rtl/prbs_order_gen.sv
module prbs_order_gen
  import prbs_pkg::*;
#(
  parameter int ORD_S = 9,
  parameter int TAP_S = 5,
  parameter int ORD_M = 15,
  parameter int TAP_M = 14,
  parameter int ORD_L = 23,
  parameter int TAP_L = 18
) (
  input  logic clk,
  input  logic rst,
  input  logic enOrd9,
  input  logic enOrd15,
  input  logic enOrd23,
  output logic serOut,
  output logic serValid
);

  localparam int NUM_ORD = 3;
  localparam int W = (ORD_L > ORD_M) ? ((ORD_L > ORD_S) ? ORD_L : ORD_S)
                                     : ((ORD_M > ORD_S) ? ORD_M : ORD_S);

  logic [NUM_ORD-1:0] enVec;
  prbsStrb_t          strb;

  assign enVec = {enOrd23, enOrd15, enOrd9};

  prbs_ctrl #(.NUM_ORD(NUM_ORD)) u_ctrl (
    .clk  (clk),
    .rst  (rst),
    .enVec(enVec),
    .strb (strb)
  );

  prbs_datapath #(
    .ORD_S(ORD_S), .TAP_S(TAP_S),
    .ORD_M(ORD_M), .TAP_M(TAP_M),
    .ORD_L(ORD_L), .TAP_L(TAP_L),
    .W    (W)
  ) u_dp (
    .clk     (clk),
    .rst     (rst),
    .strb    (strb),
    .bitOut  (serOut),
    .bitValid(serValid)
  );

  // R2: a legal enable gives a valid bit on the next edge
  a_r2_valid_follows: assert property (@(posedge clk) disable iff (rst)
    $onehot(enVec) |=> serValid);

  // R3: illegal enables quiet the outputs on the next edge
  a_r3_illegal_quiet: assert property (@(posedge clk) disable iff (rst)
    !$onehot(enVec) |=> (!serValid && !serOut));

endmodule

// File: tb/prbs_order_gen_tb.sv
module prbs_order_gen_tb;

  typedef struct {
    logic  b;
    logic  v;
    string tag;
    int    ord;
  } item_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [2:0] en = 3'b000;  // {order23, order15, order9}
  logic serOut, serValid;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  item_t q[$];
  logic obs9[$];
  int zeroRun = 0;
  int zeroBad = 0;

  logic [22:0] mState = '1;
  logic [2:0]  mPrev  = 3'b000;

  always #4 clk = ~clk;

  prbs_order_gen u_dut (
    .clk(clk), .rst(rst),
    .enOrd9(en[0]), .enOrd15(en[1]), .enOrd23(en[2]),
    .serOut(serOut), .serValid(serValid)
  );

  function automatic int ordOf(input logic [2:0] e);
    case (e)
      3'b001: return 9;
      3'b010: return 15;
      3'b100: return 23;
      default: return 0;
    endcase
  endfunction

  function automatic int tapOf(input int n);
    return (n == 9) ? 5 : (n == 15) ? 14 : 18;
  endfunction

  task automatic drive(input logic r, input logic [2:0] e, input string tag, input int n);
    for (int k = 0; k < n; k++) begin
      item_t it;
      int o;
      @(negedge clk); #1;
      rst = r; en = e;
      o = ordOf(e);
      it.tag = tag; it.ord = o;
      if (r) begin
        it.b = 0; it.v = 0; mPrev = 3'b000; mState = '1;
      end else if (o == 0) begin
        it.b = 0; it.v = 0; mPrev = e; mState = '1;
      end else begin
        if (e != mPrev) begin
          mState = '1;
          it.tag = "R7";
        end
        it.b = mState[o-1];
        it.v = 1;
        mState = {mState[21:0], mState[o-1] ^ mState[tapOf(o)-1]};
        mPrev = e;
      end
      q.push_back(it);
    end
  endtask

  // Monitor: pops one expected item per cycle and compares
  initial begin
    forever begin
      @(negedge clk);
      if (q.size() > 0) begin
        item_t it;
        it = q.pop_front();
        checks++;
        if (serOut !== it.b || serValid !== it.v) begin
          errors++;
          $display("FAIL %s: out=%b valid=%b expected out=%b valid=%b",
                   it.tag, serOut, serValid, it.b, it.v);
        end
        if (it.tag == "R4") obs9.push_back(serOut);
        if (serValid === 1'b1) begin
          zeroRun = (serOut === 1'b0) ? zeroRun + 1 : 0;
          if (it.ord > 0 && zeroRun >= it.ord) zeroBad++;
        end else begin
          zeroRun = 0;
        end
      end
    end
  end

  initial begin
    drive(1, 3'b001, "R1", 3);      // reset dominates a legal enable
    drive(0, 3'b000, "R3", 3);      // no enable
    drive(0, 3'b001, "R4", 1100);   // order 9 over two periods
    drive(0, 3'b010, "R5", 300);    // abrupt switch to order 15
    drive(0, 3'b011, "R3", 5);      // two enables
    drive(0, 3'b000, "R3", 4);      // none
    drive(0, 3'b100, "R6", 300);    // order 23
    drive(0, 3'b001, "R2", 40);     // abrupt switch to order 9
    drive(0, 3'b000, "R3", 1);      // one-cycle gap
    drive(0, 3'b001, "R2", 30);     // same order again restarts
    drive(0, 3'b110, "R3", 2);
    drive(0, 3'b001, "R2", 12);
    drive(1, 3'b001, "R1", 2);      // reset mid-run
    drive(0, 3'b010, "R5", 60);
    repeat (3) @(negedge clk);

    // R4: period of 511 and 256 ones per period
    begin
      int ones = 0;
      int mism = 0;
      for (int i = 0; i < 511; i++) begin
        if (obs9[i] === 1'b1) ones++;
        if (obs9[i] !== obs9[i+511]) mism++;
      end
      checks++;
      if (ones != 256) begin
        errors++;
        $display("FAIL R4: ones per period=%0d expected=256", ones);
      end
      checks++;
      if (mism != 0) begin
        errors++;
        $display("FAIL R4: period mismatches=%0d expected=0", mism);
      end
    end
    // R8: no run of N zeros while valid
    checks++;
    if (zeroBad != 0) begin
      errors++;
      $display("FAIL R8: long zero runs=%0d expected=0", zeroBad);
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule